// File: doc/BRIEF.md
# Two-Phase Page DMA Sequencer

This block moves one page of 512 bytes between host memory and a flash card through a staging buffer that it owns. A transfer is never a single operation: software arms one phase at a time, either the card phase (card and buffer) or the memory phase (buffer and memory), and each phase reports its own completion flag. For a read, the card phase fills the buffer and the memory phase then copies it out. For a write, the memory phase fills the buffer and the card phase then streams it to the card.

The register port is a single-cycle write strobe with a combinational read-back selected by address. The memory side is a request/acknowledge port that moves one 32-bit little-endian word per acknowledge. The card side has two byte streams with valid/ready handshakes, one inbound and one outbound. Status flags are set whether or not their interrupt is enabled. The interrupt output is the OR of the status flags that are enabled. A memory error, or a card stream that moves no byte for a programmable number of cycles, aborts the current phase and raises the error flag.

Register map (word index on `reg_addr_i`): 0 settings, 1 status, 2 interrupt enable, 3 memory base address, 4 stall limit, 5 capability.

Top module: `page_dma_seq`

## Requirements
- R1: After reset, settings, status, enable and base read 0, the stall limit reads 1024, and `irq_o`, `mem_req_o`, `card_in_ready_o` and `card_out_valid_o` are low.
- R2: Writing settings 0x6 (bit2 arms the card phase, bit1=1 selects read) accepts exactly 512 bytes on the inbound stream into the buffer. It then sets status bit2, clears both arm bits so that settings reads 0x2, and never raises `mem_req_o`.
- R3: Writing settings 0x3 (bit0 arms the memory phase, read direction) issues 128 word writes at base+4*j. Word j carries buffer bytes 4j..4j+3 with byte 4j in bits 7:0. The phase then sets status bit0 and leaves the base register unchanged.
- R4: Writing settings 0x1 (memory phase, write direction) reads 128 words from base+4*j into the buffer. A following settings 0x4 streams the 512 buffer bytes out in ascending order, little-endian within each word, and sets status bit2.
- R5: Writing the status register (bit0 memory done, bit1 error, bit2 card done) clears exactly the bits written as 1. Writing 0 bits leaves them set.
- R6: `irq_o` is high exactly when some status bit is set and its enable bit (same layout) is set. A status bit is set even when its enable bit is 0.
- R7: A memory error during the memory phase sets status bit1, drops `mem_req_o` on the next cycle, and sets no done bit.
- R8: In the card phase, when no byte moves for the number of consecutive cycles in the stall limit register, status bit1 is set and the phase stops.
- R9: Writing settings 0 stops an active phase at once and changes no status bit. Afterwards the card streams move no byte.
- R10: When both arm bits are written together, only the phase that comes first for the direction runs: the card phase for read (0x7), the memory phase for write (0x5).
- R11: The capability register reads 0xC0 (bits 6 and 7 both set: DMA supported) and ignores writes. The enable register keeps only bits 2:0, and the stall limit keeps its low 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read-back of the register at `reg_addr_i` |
| irq_o | output | 1 | Interrupt request |
| mem_req_o | output | 1 | Memory request, held until acknowledge or error |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory beat complete |
| mem_err_i | input | 1 | Memory beat failed |
| card_in_valid_i | input | 1 | Inbound card byte valid |
| card_in_data_i | input | 8 | Inbound card byte |
| card_in_ready_o | output | 1 | Block accepts an inbound byte |
| card_out_valid_o | output | 1 | Outbound card byte valid |
| card_out_data_o | output | 8 | Outbound card byte |
| card_out_ready_i | input | 1 | Card accepts the outbound byte |

## Verification
A wrong beat or byte counter shows at the ports as a phase that ends one transfer early or late. The done flag then appears in status on the wrong cycle, and the byte or word sequence seen by the bench models is shifted. A corrupted staging buffer or lane order appears only one phase later, when the data leaves through the other port, so every buffer check pairs a fill phase with a drain phase. A stuck phase state shows within one cycle as a request or ready that stays high after an error, an abort or a settings write of zero.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam logic [2:0] RA_SETTINGS = 3'd0;
  localparam logic [2:0] RA_STATUS   = 3'd1;
  localparam logic [2:0] RA_ENABLE   = 3'd2;
  localparam logic [2:0] RA_BASE     = 3'd3;
  localparam logic [2:0] RA_LIMIT    = 3'd4;
  localparam logic [2:0] RA_CAP      = 3'd5;

  // settings bits
  localparam int SB_ARM_MEM  = 0;
  localparam int SB_DIR_RD   = 1;
  localparam int SB_ARM_CARD = 2;

  typedef enum logic [1:0] {PH_IDLE, PH_CARD, PH_MEM} phase_e;
endpackage

// File: rtl/dma_page_buf.sv
module dma_page_buf #(
  parameter int DEPTH = 512,
  parameter int LANES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(LANES),
  localparam int WW = AW - LW
) (
  input  logic                 clk_i,
  input  logic                 bwe_i,
  input  logic [AW-1:0]        baddr_i,
  input  logic [7:0]           bdata_i,
  input  logic                 wwe_i,
  input  logic [WW-1:0]        waddr_i,
  input  logic [8*LANES-1:0]   wdata_i,
  input  logic [AW-1:0]        rbaddr_i,
  output logic [7:0]           rbyte_o,
  input  logic [WW-1:0]        rwaddr_i,
  output logic [8*LANES-1:0]   rword_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (bwe_i) mem_q[baddr_i] <= bdata_i;
    if (wwe_i) begin
      for (int l = 0; l < LANES; l++) mem_q[{waddr_i, LW'(l)}] <= wdata_i[8*l +: 8];
    end
  end

  assign rbyte_o = mem_q[rbaddr_i];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [LW-1:0] LANE = LW'(l);
    assign rword_o[8*l +: 8] = mem_q[{rwaddr_i, LANE}];
  end
endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int          STALL_W    = 16,
  parameter logic [15:0] STALL_INIT = 16'd1024,
  parameter bit          DMA_CAP    = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [2:0]         addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic               done_mem_i,
  input  logic               done_card_i,
  input  logic               err_i,
  output logic               restart_o,
  output logic               start_card_o,
  output logic               start_mem_o,
  output logic               dir_rd_o,
  output logic [31:0]        base_o,
  output logic [STALL_W-1:0] limit_o,
  output logic               irq_o
);
  localparam logic [7:0] CAP_VAL = DMA_CAP ? 8'hC0 : 8'h00;

  logic [2:0] settings_q, status_q, enable_q, set_vec, clr_vec;
  logic [31:0] base_q;
  logic [STALL_W-1:0] limit_q;
  logic w_set, w_stat, arm_m, arm_c, rd;

  assign w_set  = we_i && addr_i == RA_SETTINGS;
  assign w_stat = we_i && addr_i == RA_STATUS;
  assign arm_m  = wdata_i[SB_ARM_MEM];
  assign arm_c  = wdata_i[SB_ARM_CARD];
  assign rd     = wdata_i[SB_DIR_RD];
  // both armed: keep only the phase that comes first for the direction
  assign start_card_o = w_set && arm_c && (!arm_m || rd);
  assign start_mem_o  = w_set && arm_m && (!arm_c || !rd);
  assign restart_o    = w_set;

  assign set_vec = {done_card_i, err_i, done_mem_i};
  assign clr_vec = w_stat ? wdata_i[2:0] : 3'b000;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      settings_q <= '0;
      status_q   <= '0;
      enable_q   <= '0;
      base_q     <= '0;
      limit_q    <= STALL_W'(STALL_INIT);
    end else begin
      status_q <= (status_q & ~clr_vec) | set_vec;
      if (w_set) settings_q <= {start_card_o, rd, start_mem_o};
      else if (|set_vec) begin
        settings_q[SB_ARM_MEM]  <= 1'b0;
        settings_q[SB_ARM_CARD] <= 1'b0;
      end
      if (we_i && addr_i == RA_ENABLE) enable_q <= wdata_i[2:0];
      if (we_i && addr_i == RA_BASE)   base_q   <= wdata_i;
      if (we_i && addr_i == RA_LIMIT)  limit_q  <= wdata_i[STALL_W-1:0];
    end
  end

  always_comb begin
    unique case (addr_i)
      RA_SETTINGS: rdata_o = {29'd0, settings_q};
      RA_STATUS:   rdata_o = {29'd0, status_q};
      RA_ENABLE:   rdata_o = {29'd0, enable_q};
      RA_BASE:     rdata_o = base_q;
      RA_LIMIT:    rdata_o = 32'(limit_q);
      RA_CAP:      rdata_o = {24'd0, CAP_VAL};
      default:     rdata_o = '0;
    endcase
  end

  assign dir_rd_o = settings_q[SB_DIR_RD];
  assign base_o   = base_q;
  assign limit_o  = limit_q;
  assign irq_o    = |(status_q & enable_q);

  // R5: written-one bits are gone next cycle unless a new event set them
  a_r5_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_stat |=> ((status_q & $past(wdata_i[2:0] & ~set_vec)) == 3'b000));
endmodule

// File: rtl/dma_phase_ctrl.sv
module dma_phase_ctrl
  import dma_pkg::*;
#(
  parameter int PAGE    = 512,
  parameter int LANES   = 4,
  parameter int STALL_W = 16,
  localparam int CW    = $clog2(PAGE),
  localparam int BEATS = PAGE / LANES,
  localparam int BW    = $clog2(BEATS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  logic               start_card_i,
  input  logic               start_mem_i,
  input  logic               dir_rd_i,
  input  logic [31:0]        base_i,
  input  logic [STALL_W-1:0] limit_i,
  output logic               done_card_o,
  output logic               done_mem_o,
  output logic               err_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [31:0]        mem_addr_o,
  input  logic               mem_ack_i,
  input  logic               mem_err_i,
  input  logic               card_in_valid_i,
  output logic               card_in_ready_o,
  output logic               card_out_valid_o,
  input  logic               card_out_ready_i,
  output logic               buf_bwe_o,
  output logic               buf_wwe_o,
  output logic [CW-1:0]      buf_baddr_o,
  output logic [BW-1:0]      buf_waddr_o
);
  phase_e phase_q;
  logic [CW-1:0] cnt_q;
  logic [31:0] ptr_q;
  logic [STALL_W-1:0] stall_q;
  logic card_xfer, mem_xfer, card_last, mem_last, stall_hit;

  assign card_in_ready_o  = phase_q == PH_CARD && dir_rd_i;
  assign card_out_valid_o = phase_q == PH_CARD && !dir_rd_i;
  assign mem_req_o  = phase_q == PH_MEM;
  assign mem_we_o   = dir_rd_i;
  assign mem_addr_o = ptr_q;

  assign card_xfer = (card_in_ready_o && card_in_valid_i) || (card_out_valid_o && card_out_ready_i);
  assign mem_xfer  = mem_req_o && mem_ack_i && !mem_err_i;
  assign card_last = cnt_q == CW'(PAGE - 1);
  assign mem_last  = cnt_q == CW'(BEATS - 1);
  assign stall_hit = phase_q == PH_CARD && !card_xfer && stall_q == limit_i - 1'b1;

  assign done_card_o = !restart_i && card_xfer && card_last;
  assign done_mem_o  = !restart_i && mem_xfer && mem_last;
  assign err_o       = !restart_i && ((mem_req_o && mem_err_i) || stall_hit);

  assign buf_bwe_o   = card_xfer && dir_rd_i;
  assign buf_wwe_o   = mem_xfer && !dir_rd_i;
  assign buf_baddr_o = cnt_q;
  assign buf_waddr_o = cnt_q[BW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      ptr_q   <= '0;
      stall_q <= '0;
    end else if (restart_i) begin
      phase_q <= start_card_i ? PH_CARD : (start_mem_i ? PH_MEM : PH_IDLE);
      cnt_q   <= '0;
      ptr_q   <= base_i;
      stall_q <= '0;
    end else begin
      unique case (phase_q)
        PH_CARD: begin
          if (card_xfer) begin
            stall_q <= '0;
            if (card_last) phase_q <= PH_IDLE;
            else cnt_q <= cnt_q + 1'b1;
          end else if (stall_hit) phase_q <= PH_IDLE;
          else stall_q <= stall_q + 1'b1;
        end
        PH_MEM: begin
          if (mem_err_i) phase_q <= PH_IDLE;
          else if (mem_ack_i) begin
            ptr_q <= ptr_q + 32'(LANES);
            if (mem_last) phase_q <= PH_IDLE;
            else cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R7: a failed beat ends the request
  a_r7_req_drops_on_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_err_i && !restart_i) |=> !mem_req_o);
  // R3: consecutive beats step by one word
  a_r3_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && !mem_err_i && !restart_i && !done_mem_o)
      |=> (mem_req_o && mem_addr_o == $past(mem_addr_o) + 32'(LANES)));
  // R9: settings of zero idles every port
  a_r9_zero_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && !start_card_i && !start_mem_i)
      |=> (!mem_req_o && !card_in_ready_o && !card_out_valid_o));
  // R2: one port active at a time
  a_r2_one_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_req_o, card_in_ready_o, card_out_valid_o}));
endmodule

// File: rtl/page_dma_seq.sv
module page_dma_seq #(
  parameter int          PAGE_BYTES = 512,
  parameter int          MEM_BYTES  = 4,
  parameter int          STALL_W    = 16,
  parameter logic [15:0] STALL_INIT = 16'd1024,
  parameter bit          DMA_CAP    = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic [31:0] mem_rdata_i,
  input  logic        mem_ack_i,
  input  logic        mem_err_i,
  input  logic        card_in_valid_i,
  input  logic [7:0]  card_in_data_i,
  output logic        card_in_ready_o,
  output logic        card_out_valid_o,
  output logic [7:0]  card_out_data_o,
  input  logic        card_out_ready_i
);
  localparam int CW = $clog2(PAGE_BYTES);
  localparam int BW = $clog2(PAGE_BYTES / MEM_BYTES);

  logic restart, start_card, start_mem, dir_rd, done_card, done_mem, err;
  logic [31:0] base;
  logic [STALL_W-1:0] limit;
  logic bwe, wwe;
  logic [CW-1:0] baddr;
  logic [BW-1:0] waddr;
  logic [8*MEM_BYTES-1:0] rword;

  dma_regs #(.STALL_W(STALL_W), .STALL_INIT(STALL_INIT), .DMA_CAP(DMA_CAP)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .done_mem_i(done_mem), .done_card_i(done_card), .err_i(err),
    .restart_o(restart), .start_card_o(start_card), .start_mem_o(start_mem),
    .dir_rd_o(dir_rd), .base_o(base), .limit_o(limit), .irq_o
  );

  dma_phase_ctrl #(.PAGE(PAGE_BYTES), .LANES(MEM_BYTES), .STALL_W(STALL_W)) u_ctrl (
    .clk_i, .rst_ni,
    .restart_i(restart), .start_card_i(start_card), .start_mem_i(start_mem),
    .dir_rd_i(dir_rd), .base_i(base), .limit_i(limit),
    .done_card_o(done_card), .done_mem_o(done_mem), .err_o(err),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_ack_i, .mem_err_i,
    .card_in_valid_i, .card_in_ready_o, .card_out_valid_o, .card_out_ready_i,
    .buf_bwe_o(bwe), .buf_wwe_o(wwe), .buf_baddr_o(baddr), .buf_waddr_o(waddr)
  );

  dma_page_buf #(.DEPTH(PAGE_BYTES), .LANES(MEM_BYTES)) u_buf (
    .clk_i,
    .bwe_i(bwe), .baddr_i(baddr), .bdata_i(card_in_data_i),
    .wwe_i(wwe), .waddr_i(waddr), .wdata_i(mem_rdata_i),
    .rbaddr_i(baddr), .rbyte_o(card_out_data_o),
    .rwaddr_i(waddr), .rword_o(rword)
  );

  assign mem_wdata_o = rword;
endmodule

// File: tb/sim_page_dma_seq.sv
module sim_page_dma_seq;
  logic clk = 0, rst_ni = 0;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, mem_req, mem_we, mem_ack = 0, mem_err = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic cin_valid = 0, cin_ready, cout_valid, cout_ready = 0;
  logic [7:0] cin_data = 0, cout_data;

  int n_chk = 0, n_fail = 0;
  int src_n = 0, sink_n = 0, beats = 0, req_seen = 0, valid_seen = 0, err_at = -1;
  bit src_on = 0, sink_on = 0, mem_on = 0;
  logic [31:0] wr_addr [128];
  logic [31:0] wr_data [128];
  logic [7:0]  sink_buf [512];

  always #10 clk = ~clk;

  page_dma_seq u0 (
    .clk_i(clk), .rst_ni, .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_ack_i(mem_ack), .mem_err_i(mem_err), .card_in_valid_i(cin_valid),
    .card_in_data_i(cin_data), .card_in_ready_o(cin_ready), .card_out_valid_o(cout_valid),
    .card_out_data_o(cout_data), .card_out_ready_i(cout_ready)
  );

  function automatic logic [7:0] pat(int i);
    return 8'(i * 13 + (i >> 8) * 5 + 7);
  endfunction
  function automatic logic [31:0] mfun(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h13572468;
  endfunction

  // memory model: decisions at the falling edge, effective at the next rising edge
  always @(negedge clk) begin
    mem_ack = 0; mem_err = 0;
    if (mem_req) req_seen++;
    if (mem_on && mem_req) begin
      if (err_at == beats) mem_err = 1;
      else begin
        mem_ack = 1;
        mem_rdata = mfun(mem_addr);
        if (mem_we && beats < 128) begin wr_addr[beats] = mem_addr; wr_data[beats] = mem_wdata; end
        beats++;
      end
    end
  end

  // card model
  always @(negedge clk) begin
    cout_ready = sink_on;
    if (cout_valid) valid_seen++;
    if (sink_on && cout_valid) begin
      if (sink_n < 512) sink_buf[sink_n] = cout_data;
      sink_n++;
    end
    cin_valid = src_on;
    cin_data = pat(src_n);
    if (src_on && cin_ready) src_n++;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // {write, addr, wdata, expected read-back}
  localparam logic [67:0] VEC [8] = '{
    {1'b1, 3'd2, 32'h0000_0007, 32'h0000_0007},
    {1'b1, 3'd2, 32'h0000_00FF, 32'h0000_0007},
    {1'b1, 3'd2, 32'h0000_0000, 32'h0000_0000},
    {1'b1, 3'd3, 32'h1234_5678, 32'h1234_5678},
    {1'b1, 3'd4, 32'h0003_0050, 32'h0000_0050},
    {1'b0, 3'd5, 32'h0000_0000, 32'h0000_00C0},
    {1'b1, 3'd5, 32'h0000_00FF, 32'h0000_00C0},
    {1'b1, 3'd4, 32'h0000_0400, 32'h0000_0400}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int bad;
    wait_cyc(3);
    rst_ni = 1;
    wait_cyc(1);

    // R1 reset state
    rd(3'd0, v); chk("R1 settings", v, 0);
    rd(3'd1, v); chk("R1 status", v, 0);
    rd(3'd2, v); chk("R1 enable", v, 0);
    rd(3'd3, v); chk("R1 base", v, 0);
    rd(3'd4, v); chk("R1 limit", v, 32'd1024);
    chk("R1 ports", {28'd0, irq, mem_req, cin_ready, cout_valid}, 0);

    // R11 register table
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][67]) wr(VEC[i][66:64], VEC[i][63:32]);
      rd(VEC[i][66:64], v);
      chk($sformatf("R11 vector %0d", i), v, VEC[i][31:0]);
    end

    // R2 read: card phase
    wr(3'd3, 32'h0000_2000);
    mem_on = 1; req_seen = 0; src_n = 0; src_on = 1;
    wr(3'd0, 32'h6);
    wait_cyc(560);
    src_on = 0;
    chk("R2 bytes taken", 32'(src_n), 512);
    rd(3'd1, v); chk("R2 card done", v, 32'h4);
    rd(3'd0, v); chk("R2 arm cleared", v, 32'h2);
    chk("R2 no memory request", 32'(req_seen), 0);
    chk("R6 irq masked", {31'd0, irq}, 0);

    // R6 / R5
    wr(3'd2, 32'h4); wait_cyc(1);
    chk("R6 irq enabled", {31'd0, irq}, 1);
    wr(3'd1, 32'h3);
    rd(3'd1, v); chk("R5 zero bits keep", v, 32'h4);
    wr(3'd1, 32'h4);
    rd(3'd1, v); chk("R5 clear", v, 0);
    chk("R6 irq low after clear", {31'd0, irq}, 0);
    wr(3'd2, 32'h0);

    // R3 read: memory phase
    beats = 0;
    wr(3'd0, 32'h3);
    wait_cyc(200);
    rd(3'd1, v); chk("R3 memory done", v, 32'h1);
    chk("R3 beat count", 32'(beats), 128);
    bad = 0;
    for (int j = 0; j < 128; j++) begin
      if (wr_addr[j] !== 32'h2000 + 32'(4 * j)) bad++;
      if (wr_data[j] !== {pat(4*j+3), pat(4*j+2), pat(4*j+1), pat(4*j)}) bad++;
    end
    chk("R3 words and addresses", 32'(bad), 0);
    rd(3'd3, v); chk("R3 base unchanged", v, 32'h2000);
    wr(3'd1, 32'h7);

    // R4 write: memory then card
    wr(3'd3, 32'h0001_0400);
    beats = 0;
    wr(3'd0, 32'h1);
    wait_cyc(200);
    rd(3'd1, v); chk("R4 memory done", v, 32'h1);
    sink_n = 0; sink_on = 1;
    wr(3'd0, 32'h4);
    wait_cyc(560);
    sink_on = 0;
    chk("R4 bytes sent", 32'(sink_n), 512);
    bad = 0;
    for (int k = 0; k < 512; k++) begin
      v = mfun(32'h0001_0400 + 32'(4 * (k / 4)));
      if (sink_buf[k] !== v[8*(k%4) +: 8]) bad++;
    end
    chk("R4 byte order", 32'(bad), 0);
    rd(3'd1, v); chk("R4 both done", v, 32'h5);
    wr(3'd1, 32'h7);

    // R7 memory error
    beats = 0; err_at = 10;
    wr(3'd0, 32'h1);
    wait_cyc(50);
    err_at = -1;
    rd(3'd1, v); chk("R7 error only", v, 32'h2);
    chk("R7 request dropped", {31'd0, mem_req}, 0);
    chk("R7 beats before error", 32'(beats), 10);
    rd(3'd0, v); chk("R7 arm cleared", v, 0);
    wr(3'd1, 32'h7);

    // R8 card stall
    wr(3'd4, 32'd20);
    src_on = 0;
    wr(3'd0, 32'h6);
    wait_cyc(15);
    rd(3'd1, v); chk("R8 before limit", v, 0);
    wait_cyc(30);
    rd(3'd1, v); chk("R8 stall error", v, 32'h2);
    chk("R8 phase stopped", {31'd0, cin_ready}, 0);
    wr(3'd1, 32'h7);

    // R9 abort by zero
    wr(3'd4, 32'd1000);
    wr(3'd0, 32'h6);
    wait_cyc(10);
    wr(3'd0, 32'h0);
    wait_cyc(5);
    chk("R9 ready low", {31'd0, cin_ready}, 0);
    rd(3'd1, v); chk("R9 status unchanged", v, 0);
    src_n = 0; src_on = 1;
    wait_cyc(10);
    src_on = 0;
    chk("R9 no byte moved", 32'(src_n), 0);

    // R10 both arms
    src_n = 0; src_on = 1; req_seen = 0;
    wr(3'd0, 32'h7);
    wait_cyc(560);
    src_on = 0;
    rd(3'd1, v); chk("R10 read runs card only", v, 32'h4);
    chk("R10 read no memory request", 32'(req_seen), 0);
    wr(3'd1, 32'h7);
    valid_seen = 0; beats = 0;
    wr(3'd0, 32'h5);
    wait_cyc(200);
    rd(3'd1, v); chk("R10 write runs memory only", v, 32'h1);
    chk("R10 write no card byte", 32'(valid_seen), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule